// File: doc/BRIEF.md
# H-Bridge Cell Gate Decoder with Switch-Fault Protection

This block drives the four power switches of a single H-bridge cell. Two such cells are stacked to form one phase of a five-level cascaded inverter. Each clock, a modulator asks the block for a cell output level of plus one, zero or minus one times the DC-link voltage. The block returns the gate pattern that produces that level.

When a fault detector reports a failed switch, the block takes three actions:

- It pins the faulty leg into a safe state. The partner switch is held on after an open failure and held off after a short failure, so the leg can never shoot through.
- It reports which extreme level the cell has lost.
- It replaces any request the cell can no longer meet with the nearest level it can still produce, and records that this happened in a sticky flag.

For a zero request, the block chooses between the two zero-producing patterns so that the fewest gates toggle. The choice is restricted to whichever pattern remains possible under the fault.

Top module: `hbcell_gate_dec`

## Requirements
- R1: The request encodes 2'b01 = +1, 2'b00 = 0 and 2'b11 = −1. Gate bits are bit0 = S1, bit1 = S2, bit2 = S3, bit3 = S4. A +1 request gives 4'b1001 and a −1 request gives 4'b0110. All outputs are registered and reflect the inputs present at the preceding rising clock edge.
- R2: The pairs S1/S3 and S2/S4 are always complementary: exactly one switch of each pair is on.
- R3: Class F1 (top level lost) covers an open S1 or S4 and a shorted S2 or S3. It is reported as loss flag 2'b01, and +1 is never produced while it is active.
- R4: Class F2 (bottom level lost) covers an open S2 or S3 and a shorted S1 or S4. It is reported as loss flag 2'b10, and −1 is never produced while it is active. With no valid fault the loss flag is 2'b00.
- R5: Under a valid fault (switch index 0..3 = S1..S4, kind 1 = short), the faulty switch's gate equals the kind bit and its partner's gate is the inverse.
- R6: An open fault does not halt the cell. Every level that remains realisable is still produced on request.
- R7: A zero request with no fault selects S1+S2 (4'b0011) or S3+S4 (4'b1100), whichever differs from the current gates in fewer bits. A tie selects 4'b1100. Under a fault, the single zero pattern consistent with R5 is used.
- R8: A request for a lost level produces 0 instead and sets the clipped flag. The flag stays set until reset.
- R9: Code 2'b10 is an out-of-range −2 request. It produces −1, or 0 under F2, and always sets the clipped flag.
- R10: While reset is asserted, and on the first cycle after it, the gates read 4'b1100, the loss flag 2'b00 and the clipped flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | 2 | Requested cell level code |
| flt_vld | input | 1 | A switch fault is reported |
| flt_sw | input | 2 | Faulty switch index, 0..3 = S1..S4 |
| flt_short | input | 1 | Fault kind: 1 short circuit, 0 open circuit |
| gate_o | output | 4 | Gate commands, bit0 = S1 .. bit3 = S4 |
| lost_lvl_o | output | 2 | 2'b01 top level lost, 2'b10 bottom level lost |
| clipped_o | output | 1 | Sticky flag: a request was substituted |

## Verification
Every output is due exactly one rising edge after its inputs change. The bench therefore drives the inputs on a falling edge and reads all three outputs at the next falling edge, one edge later.

The zero-state choice depends on the gates already applied, so the bench carries its own model of the previous gate pattern. It applies every pair of consecutive requests under each of the nine fault conditions, which exercises every transition origin.

Sticky behaviour is checked by carrying the expected clipped state across the whole sweep and then confirming that reset clears it.

// File: rtl/hbcell_pkg.sv
package hbcell_pkg;
  localparam int unsigned SW_N  = 4;
  localparam int unsigned IDX_W = $clog2(SW_N);

  typedef enum logic [1:0] {
    LVL_ZERO    = 2'b00,
    LVL_POS     = 2'b01,
    LVL_OVR_NEG = 2'b10,
    LVL_NEG     = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    LOSS_NONE = 2'b00,
    LOSS_TOP  = 2'b01,
    LOSS_BOT  = 2'b10
  } loss_e;

  // pinned leg description: leg 0 = S1/S3, leg 1 = S2/S4; val = upper switch on
  typedef struct packed {
    logic pinned;
    logic leg;
    logic val;
  } pin_t;
endpackage

// File: rtl/hbcell_fault_map.sv
module hbcell_fault_map
  import hbcell_pkg::*;
(
  input  logic             flt_vld,
  input  logic [IDX_W-1:0] flt_sw,
  input  logic             flt_short,
  output pin_t             pin,
  output loss_e            loss
);
  logic upper_sw;
  logic top_gone;

  always_comb begin
    // S1,S2 are upper switches of their legs; S3,S4 lower
    upper_sw   = ~flt_sw[1];
    pin.pinned = flt_vld;
    pin.leg    = flt_sw[0];
    // short keeps the faulty switch conducting, open keeps it off
    pin.val    = upper_sw ? flt_short : ~flt_short;
    // leg A pinned low or leg B pinned high forbids the positive state
    top_gone   = ~(pin.val ^ pin.leg);
    if (!flt_vld)      loss = LOSS_NONE;
    else if (top_gone) loss = LOSS_TOP;
    else               loss = LOSS_BOT;
  end
endmodule

// File: rtl/hbcell_level_sel.sv
module hbcell_level_sel
  import hbcell_pkg::*;
#(
  parameter bit TIE_LOW = 1'b1
) (
  input  logic [1:0] lvl_req,
  input  pin_t       pin,
  input  loss_e      loss,
  input  logic       cur_a,
  input  logic       cur_b,
  output logic       nxt_a,
  output logic       nxt_b,
  output logic       clip_hit
);
  logic [1:0] cost_hi;
  logic [1:0] cost_lo;
  logic       zero_val;
  lvl_e       req;

  always_comb begin
    cost_hi = {1'b0, ~cur_a} + {1'b0, ~cur_b};
    cost_lo = {1'b0, cur_a} + {1'b0, cur_b};
    if (pin.pinned)             zero_val = pin.val;
    else if (cost_hi < cost_lo) zero_val = 1'b1;
    else if (cost_lo < cost_hi) zero_val = 1'b0;
    else                        zero_val = ~TIE_LOW;
  end

  always_comb begin
    req      = lvl_e'(lvl_req);
    nxt_a    = zero_val;
    nxt_b    = zero_val;
    clip_hit = 1'b0;
    unique case (req)
      LVL_POS: begin
        if (loss == LOSS_TOP) clip_hit = 1'b1;
        else begin
          nxt_a = 1'b1;
          nxt_b = 1'b0;
        end
      end
      LVL_NEG: begin
        if (loss == LOSS_BOT) clip_hit = 1'b1;
        else begin
          nxt_a = 1'b0;
          nxt_b = 1'b1;
        end
      end
      LVL_OVR_NEG: begin
        clip_hit = 1'b1;
        if (loss != LOSS_BOT) begin
          nxt_a = 1'b0;
          nxt_b = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hbcell_gate_dec.sv
module hbcell_gate_dec
  import hbcell_pkg::*;
#(
  parameter bit TIE_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_req,
  input  logic       flt_vld,
  input  logic [1:0] flt_sw,
  input  logic       flt_short,
  output logic [3:0] gate_o,
  output logic [1:0] lost_lvl_o,
  output logic       clipped_o
);
  pin_t  pin;
  loss_e loss;
  logic  a_q, b_q, a_d, b_d;
  loss_e loss_q;
  logic  clip_q, clip_d, clip_hit, clip_en;

  hbcell_fault_map i_map (
    .flt_vld  (flt_vld),
    .flt_sw   (flt_sw),
    .flt_short(flt_short),
    .pin      (pin),
    .loss     (loss)
  );

  hbcell_level_sel #(.TIE_LOW(TIE_LOW)) i_sel (
    .lvl_req (lvl_req),
    .pin     (pin),
    .loss    (loss),
    .cur_a   (a_q),
    .cur_b   (b_q),
    .nxt_a   (a_d),
    .nxt_b   (b_d),
    .clip_hit(clip_hit)
  );

  always_comb begin
    clip_en = clip_hit & ~clip_q;
    clip_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      loss_q <= LOSS_NONE;
      clip_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      loss_q <= loss;
      if (clip_en) clip_q <= clip_d;
    end
  end

  assign gate_o     = {~b_q, ~a_q, b_q, a_q};
  assign lost_lvl_o = loss_q;
  assign clipped_o  = clip_q;

  // R5
  prot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_vld |=> (gate_o[$past(flt_sw)] == $past(flt_short)) &&
                (gate_o[$past(flt_sw) ^ 2'd2] == ~$past(flt_short)));

  // R3
  no_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_lvl_o == LOSS_TOP) |-> (gate_o != 4'b1001));

  // R4
  no_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_lvl_o == LOSS_BOT) |-> (gate_o != 4'b0110));

  // R8
  clip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clipped_o |=> clipped_o);

  // R7
  zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req == 2'b00) |=> (gate_o == 4'b0011) || (gate_o == 4'b1100));

  // R2
  leg_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_o) == 2);
endmodule

// File: tb/test_hbcell_gate_dec.sv
module test_hbcell_gate_dec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] lvl_req;
  logic       flt_vld;
  logic [1:0] flt_sw;
  logic       flt_short;
  logic [3:0] gate_o;
  logic [1:0] lost_lvl_o;
  logic       clipped_o;

  int   n_run  = 0;
  int   n_fail = 0;
  logic [3:0] exp_prev;
  logic       exp_clip;

  always #4 clk = ~clk;

  hbcell_gate_dec i_hbcell_gate_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_req   (lvl_req),
    .flt_vld   (flt_vld),
    .flt_sw    (flt_sw),
    .flt_short (flt_short),
    .gate_o    (gate_o),
    .lost_lvl_o(lost_lvl_o),
    .clipped_o (clipped_o)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic is_f1(input logic fv, input logic [1:0] sw, input logic sh);
    return fv && ((!sh && (sw == 2'd0 || sw == 2'd3)) || (sh && (sw == 2'd1 || sw == 2'd2)));
  endfunction

  // model built from the requirement text: levels, clipping, zero-pattern choice
  function automatic logic [3:0] model(input logic [1:0] req, input logic fv,
                                       input logic [1:0] sw, input logic sh,
                                       input logic [3:0] prev, output logic clipd);
    int lv, hi, lo;
    logic f1, f2;
    logic [3:0] c_hi, c_lo;
    f1 = is_f1(fv, sw, sh);
    f2 = fv && !f1;
    case (req)
      2'b01: lv = 1;
      2'b11: lv = -1;
      2'b10: lv = -2;
      default: lv = 0;
    endcase
    hi = f1 ? 0 : 1;
    lo = f2 ? 0 : -1;
    clipd = (req == 2'b10);
    if (lv > hi) begin lv = hi; clipd = 1'b1; end
    if (lv < lo) begin lv = lo; clipd = 1'b1; end
    c_hi = 4'b0011;
    c_lo = 4'b1100;
    if (lv == 1) return 4'b1001;
    if (lv == -1) return 4'b0110;
    if (fv) return (c_hi[sw] == sh) ? c_hi : c_lo;
    if ($countones(prev ^ c_hi) < $countones(prev ^ c_lo)) return c_hi;
    return c_lo;
  endfunction

  task automatic step(input logic [1:0] req, input logic fv, input logic [1:0] sw, input logic sh);
    logic [3:0] eg;
    logic       ec;
    logic [1:0] el;
    @(negedge clk);
    lvl_req = req; flt_vld = fv; flt_sw = sw; flt_short = sh;
    eg = model(req, fv, sw, sh, exp_prev, ec);
    exp_clip = exp_clip | ec;
    el = !fv ? 2'b00 : (is_f1(fv, sw, sh) ? 2'b01 : 2'b10);
    @(negedge clk);
    // R1 R2 R5 R6 R7 R9: gate pattern one edge after the request
    check($sformatf("R1/R5/R7 gate req=%b f=%b sw=%0d sh=%b", req, fv, sw, sh), gate_o, eg);
    // R3 R4: loss class
    check($sformatf("R3/R4 loss f=%b sw=%0d sh=%b", fv, sw, sh), {2'b00, lost_lvl_o}, {2'b00, el});
    // R8 R9: sticky clipped flag
    check($sformatf("R8/R9 clipped req=%b", req), {3'b000, clipped_o}, {3'b000, exp_clip});
    exp_prev = eg;
  endtask

  initial begin
    rst_n = 1'b0; lvl_req = 2'b01; flt_vld = 1'b0; flt_sw = 2'd0; flt_short = 1'b0;
    exp_prev = 4'b1100; exp_clip = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 gate in reset", gate_o, 4'b1100);
    check("R10 loss in reset", {2'b00, lost_lvl_o}, 4'b0000);
    check("R10 clipped in reset", {3'b000, clipped_o}, 4'b0000);
    lvl_req = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 gate after release", gate_o, 4'b1100);
    // fault-free part first so the clipped flag only rises on clipping
    for (int r1 = 0; r1 < 4; r1++)
      for (int r2 = 0; r2 < 4; r2++) begin
        if (r1 == 2 || r2 == 2) continue;
        step(2'(r1), 1'b0, 2'd0, 1'b0);
        step(2'(r2), 1'b0, 2'd0, 1'b0);
      end
    // R6 R8: every fault with every pair of consecutive requests
    for (int f = 0; f < 8; f++)
      for (int r1 = 0; r1 < 4; r1++)
        for (int r2 = 0; r2 < 4; r2++) begin
          step(2'(r1), 1'b1, 2'(f % 4), 1'(f / 4));
          step(2'(r2), 1'b1, 2'(f % 4), 1'(f / 4));
        end
    // R9: out-of-range code without a fault, then zero tie checks
    for (int r1 = 0; r1 < 4; r1++)
      for (int r2 = 0; r2 < 4; r2++) begin
        step(2'(r1), 1'b0, 2'd0, 1'b0);
        step(2'(r2), 1'b0, 2'd0, 1'b0);
      end
    // R10 R8: reset clears sticky flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 clipped cleared", {3'b000, clipped_o}, 4'b0000);
    check("R10 gate after reset", gate_o, 4'b1100);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule